// File: doc/BRIEF.md
# Prescaled Event Timer

An 8-bit up-counting timer for a small microcontroller core. It advances on one of two event sources: a one-cycle enable pulse that marks each internal instruction cycle, or a chosen edge of an external timer pin. The pin is brought into the system clock domain before its edges are looked for. An optional power-of-two prescaler can sit between the event source and the counter. A mode bit bypasses it, and the timer then counts 1:1.

Software reaches two byte-wide registers over a simple write-strobe and address bus with a combinational read port. One is the control byte. The other is the live count, which can also be loaded. When the count wraps from 0xFF to 0x00 the block raises a one-cycle strobe, which the interrupt controller latches as its overflow flag. The control byte also holds the external-interrupt edge bit, which is driven out on a pin. It shows the global interrupt enable as a read-only bit taken from the interrupt controller.

Pin edges are found by a two-state machine that tracks the synchronized pin level. In state PIN_LOW, a high level takes the transition LOW_TO_HIGH and raises a rise event for that cycle. In state PIN_HIGH, a low level takes the transition HIGH_TO_LOW and raises a fall event. If the level does not change, the machine stays where it is and no event is raised. Reset puts the machine in PIN_LOW.

Top module: `tmr_unit`

## Requirements
- R1: After reset the count reads 0x00 and `ovf_o` is 0. The control byte reads 0x00 apart from bit 6, which reads `gie_i`.
- R2: Control byte fields, bit 7 down to bit 0: irq edge (7), global enable (6, read-only), source select (5), pin falling (4), prescaler enable (3), ratio (2:0). Address 0 selects the control byte and address 1 selects the count. Data written to bit 6 is ignored, and reading bit 6 always returns the current `gie_i`.
- R3: With source select 0, each cycle in which `tick_i` is 1 makes one count event. The counter changes only on a counted event or a write.
- R4: With source select 1 and pin falling 0, a low-to-high pin change is one event, and `tick_i` is ignored. With the prescaler off, the new count is visible after the third rising clock edge that follows the pin change.
- R5: With source select 1 and pin falling 1, only high-to-low pin changes count. The two edge kinds are never raised in the same cycle.
- R6: With the prescaler enabled, ratio code n advances the counter once per 2^(n+1) events (1:2 up to 1:256).
- R7: With the prescaler disabled, every event advances the counter, whatever the ratio bits hold.
- R8: A count write loads the written value on the next edge with no increment in that cycle, and it clears the prescaler.
- R9: `ovf_o` is 1 for exactly the one cycle in which the count has just wrapped from 0xFF to 0x00 through counting. A write that loads 0x00 does not raise it.
- R10: `irq_edge_o` follows control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-cycle enable pulse |
| tpin_i | input | 1 | External timer pin, asynchronous |
| gie_i | input | 1 | Global interrupt enable, shown in control bit 6 |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control byte, 1 = count |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_edge_o | output | 1 | External-interrupt edge select |
| ovf_o | output | 1 | One-cycle wrap strobe |

## Verification
The bench probes count writes that land in the same cycle as an event. A design that let the increment through would read one above the written value. It also writes 0xFF while events keep arriving, and writes 0x00 directly. A wrong overflow strobe would then be missing at the wrap or appear after the load. Every ratio code is run with a continuous event stream, and the ratio is later changed in the middle of a count. An off-by-one prescaler divides by the wrong power of two. A prescaler that ignores the enable bit keeps dividing when it should count 1:1. The bench toggles the pin at random, including pulses too short to cross the synchronizer cleanly, while `tick_i` also toggles. A wrong synchronizer depth shifts the count by a cycle. A swapped edge select counts the wrong edge. A source mux that leaks lets instruction ticks through in pin mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 8;
    localparam int RATIO_W = 3;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    typedef struct packed {
        logic               irq_edge;
        logic               gie;
        logic               src_pin;
        logic               pin_fall;
        logic               psc_en;
        logic [RATIO_W-1:0] ratio;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);

    logic [SYNC_N-1:0] sync_q;
    logic              lvl;
    pin_state_e        state_q, state_d;
    logic              rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], pin_i};
    end

    assign lvl = sync_q[SYNC_N-1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (lvl)  state_d = PIN_HIGH;
            PIN_HIGH: if (!lvl) state_d = PIN_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            PIN_LOW:  rise = lvl;
            PIN_HIGH: fall = !lvl;
        endcase
    end

    assign edge_o = fall_sel_i ? fall : rise;

    // R5
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));

    // R4
    rise_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state_q == PIN_HIGH));

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               ev_i,
    input  logic               clr_i,
    output logic               pulse_o
);

    localparam int PW = 1 << RATIO_W;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim;
    logic          hit;

    assign lim = (PW'(1) << ({1'b0, ratio_i} + (RATIO_W+1)'(1))) - PW'(1);
    assign hit = (cnt_q >= lim);

    always_comb begin
        if (clr_i)      pulse_o = 1'b0;
        else if (en_i)  pulse_o = ev_i && hit;
        else            pulse_o = ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr_i || !en_i)  cnt_q <= '0;
        else if (ev_i)            cnt_q <= hit ? '0 : cnt_q + PW'(1);
    end

    // R6
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> ev_i);

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && ev_i && !clr_i) |-> pulse_o);

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            wrap_o <= 1'b0;
        end else if (load_i) begin
            cnt_o  <= load_val_i;
            wrap_o <= 1'b0;
        end else if (inc_i) begin
            cnt_o  <= cnt_o + W'(1);
            wrap_o <= &cnt_o;
        end else begin
            wrap_o <= 1'b0;
        end
    end

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (cnt_o == '0));

    // R9
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

    // R8
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(load_val_i)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !inc_i) |=> $stable(cnt_o));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             tpin_i,
    input  logic             gie_i,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_edge_o,
    output logic             ovf_o
);

    logic               irq_edge_q, src_pin_q, pin_fall_q, psc_en_q;
    logic [RATIO_W-1:0] ratio_q;
    tmr_ctrl_t          ctrl_rd;
    logic               wr_ctrl, wr_cnt;
    logic               pin_ev, ev, cnt_inc;
    logic [CNT_W-1:0]   cnt;

    assign wr_ctrl = wr_i && !addr_i;
    assign wr_cnt  = wr_i && addr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_edge_q <= 1'b0;
            src_pin_q  <= 1'b0;
            pin_fall_q <= 1'b0;
            psc_en_q   <= 1'b0;
            ratio_q    <= '0;
        end else if (wr_ctrl) begin
            irq_edge_q <= wdata_i[7];
            src_pin_q  <= wdata_i[5];
            pin_fall_q <= wdata_i[4];
            psc_en_q   <= wdata_i[3];
            ratio_q    <= wdata_i[RATIO_W-1:0];
        end
    end

    tmr_pin_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (tpin_i),
        .fall_sel_i (pin_fall_q),
        .edge_o     (pin_ev)
    );

    assign ev = src_pin_q ? pin_ev : tick_i;

    tmr_prescaler #(.RATIO_W(RATIO_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (psc_en_q),
        .ratio_i (ratio_q),
        .ev_i    (ev),
        .clr_i   (wr_cnt),
        .pulse_o (cnt_inc)
    );

    tmr_count #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_cnt),
        .load_val_i (wdata_i),
        .inc_i      (cnt_inc),
        .cnt_o      (cnt),
        .wrap_o     (ovf_o)
    );

    always_comb begin
        ctrl_rd.irq_edge = irq_edge_q;
        ctrl_rd.gie      = gie_i;
        ctrl_rd.src_pin  = src_pin_q;
        ctrl_rd.pin_fall = pin_fall_q;
        ctrl_rd.psc_en   = psc_en_q;
        ctrl_rd.ratio    = ratio_q;
    end

    assign rdata_o    = addr_i ? cnt : ctrl_rd;
    assign irq_edge_o = irq_edge_q;

    // R4
    src_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pin_q && !pin_ev && !wr_cnt) |=> $stable(cnt));

    // R10
    irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (irq_edge_o == $past(wdata_i[7])));

endmodule

// File: tb/tb_tmr_unit.sv
`timescale 1ns/1ps
module tb_tmr_unit;

    logic       clk = 1'b0;
    logic       rst_n, tick, tpin, gie, wr, addr;
    logic [7:0] wdata, rdata;
    logic       irq_edge, ovf;

    always #2 clk = ~clk;

    tmr_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .tpin_i(tpin), .gie_i(gie),
        .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_edge_o(irq_edge), .ovf_o(ovf)
    );

    int vectors = 0, errors = 0;
    bit done = 0;
    string tag;

    logic [7:0] m_cnt, m_psc;
    logic       m_ovf, m_s1, m_s2, m_lvl;
    logic       m_edge, m_src, m_fall, m_pen;
    logic [2:0] m_ratio;

    function automatic logic [7:0] lim_f(input logic [2:0] r);
        return 8'((9'd1 << (r + 1)) - 9'd1);
    endfunction

    function automatic logic [7:0] exp_rd(input logic a);
        return a ? m_cnt : {m_edge, gie, m_src, m_fall, m_pen, m_ratio};
    endfunction

    task automatic check();
        vectors++;
        if (rdata !== exp_rd(addr) || ovf !== m_ovf || irq_edge !== m_edge) begin
            errors++;
            $display("FAIL %s: addr=%0d rdata=%h ovf=%b edge=%b expected rdata=%h ovf=%b edge=%b",
                     tag, addr, rdata, ovf, irq_edge, exp_rd(addr), m_ovf, m_edge);
        end
    endtask

    task automatic step();
        logic rise, fall, ev;
        rise = !m_lvl && m_s2;
        fall = m_lvl && !m_s2;
        ev = m_src ? (m_fall ? fall : rise) : tick;
        m_ovf = 1'b0;
        if (wr && addr) begin
            m_cnt = wdata; m_psc = 8'd0;
        end else if (!m_pen) begin
            m_psc = 8'd0;
            if (ev) begin m_ovf = (m_cnt == 8'hFF); m_cnt = m_cnt + 8'd1; end
        end else if (ev) begin
            if (m_psc >= lim_f(m_ratio)) begin
                m_psc = 8'd0; m_ovf = (m_cnt == 8'hFF); m_cnt = m_cnt + 8'd1;
            end else m_psc = m_psc + 8'd1;
        end
        if (wr && !addr) begin
            m_edge = wdata[7]; m_src = wdata[5]; m_fall = wdata[4];
            m_pen = wdata[3]; m_ratio = wdata[2:0];
        end
        m_lvl = m_s2; m_s2 = m_s1; m_s1 = tpin;
        @(posedge clk);
        @(negedge clk);
        check();
    endtask

    task automatic cyc(input logic w, input logic a, input logic [7:0] d,
                       input logic t, input logic p);
        wr = w; addr = a; wdata = d; tick = t; tpin = p;
        step();
    endtask

    task automatic rnd(input int n, input int wprob, input logic force_tick);
        for (int i = 0; i < n; i++) begin
            gie  = 1'($urandom % 2);
            tick = force_tick ? 1'b1 : 1'($urandom % 2);
            if ($urandom % 4 == 0) tpin = ~tpin;
            addr = 1'($urandom % 2);
            wr   = (wprob > 0) && ($urandom % wprob == 0);
            if (wr) addr = 1'b1;
            wdata = 8'($urandom);
            step();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_7A11));
        rst_n = 1'b0; tick = 0; tpin = 0; gie = 0; wr = 0; addr = 0; wdata = 0;
        m_cnt = 0; m_psc = 0; m_ovf = 0; m_s1 = 0; m_s2 = 0; m_lvl = 0;
        m_edge = 0; m_src = 0; m_fall = 0; m_pen = 0; m_ratio = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tag = "R1"; addr = 0; #0.1 check();
        addr = 1; #0.1 check();
        gie = 1; addr = 0; #0.1 check();

        // R2 bit 6 ignores writes, follows gie_i
        tag = "R2";
        gie = 0; cyc(1, 0, 8'hFF, 0, 0);
        cyc(0, 0, 8'h00, 0, 0);
        gie = 1; cyc(1, 0, 8'h00, 0, 0);
        cyc(0, 0, 8'h00, 0, 0);

        // R10 edge bit
        tag = "R10"; cyc(1, 0, 8'h80, 0, 0); cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 8'h00, 0, 0); cyc(0, 0, 0, 0, 0);

        // R3 instruction-cycle counting
        tag = "R3"; cyc(1, 0, 8'h00, 0, 0); rnd(200, 0, 0);

        // R8 write with a simultaneous event: no increment
        tag = "R8"; cyc(1, 1, 8'h10, 1, tpin); cyc(0, 1, 0, 0, tpin);
        rnd(150, 3, 0);

        // R9 wrap and load of zero
        tag = "R9"; cyc(1, 1, 8'hFE, 1, tpin);
        cyc(0, 1, 0, 1, tpin); cyc(0, 1, 0, 1, tpin); cyc(0, 1, 0, 0, tpin);
        cyc(1, 1, 8'hFF, 1, tpin); cyc(1, 1, 8'h00, 1, tpin); cyc(0, 1, 0, 0, tpin);
        rnd(600, 0, 1);

        // R4 rising pin edges, tick ignored
        tag = "R4"; cyc(1, 0, 8'h20, 0, tpin); rnd(400, 20, 0);
        // R5 falling pin edges
        tag = "R5"; cyc(1, 0, 8'h30, 0, tpin); rnd(400, 20, 0);

        // R6 every ratio code
        tag = "R6";
        for (int n = 0; n < 8; n++) begin
            cyc(1, 0, 8'h08 | 8'(n), 1, tpin);
            cyc(1, 1, 8'h00, 1, tpin);
            rnd((2 << n) * 3 + 10, 0, 1);
        end
        cyc(1, 0, 8'h0F, 1, tpin); rnd(70, 0, 1);
        cyc(1, 0, 8'h09, 1, tpin); rnd(30, 0, 1);
        cyc(1, 0, 8'h2A, 0, tpin); rnd(400, 40, 0);

        // R7 prescaler off ignores ratio
        tag = "R7"; cyc(1, 0, 8'h05, 1, tpin); rnd(300, 0, 1);

        tag = "mix";
        for (int k = 0; k < 20; k++) begin
            cyc(1, 0, 8'($urandom), 0, tpin);
            rnd(150, 25, 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule